// File: doc/BRIEF.md
# Hall Commutation Tracker with Shadowed Channel Mask

This block follows a three-input Hall sensor and checks each sampled pattern against two reference patterns. One is the rotor position the motor is in now (the current pattern). The other is the position it should reach next (the expected pattern). A sample that matches the expected pattern counts as a correct commutation step, and the tracker then moves forward by one position. A sample that matches neither reference counts as a wrong step. A sample equal to the current pattern is treated as no movement.

The block also holds a six-bit channel mask, two bits per PWM phase, that decides which of the three phase outputs and the three complementary outputs may follow the PWM. Software writes the next mask into a shadow register. A selectable trigger requests the copy into the active mask. A selectable synchronisation event completes the copy. Between the trigger and the synchronisation event, a pending flag holds the request. Both Hall reference patterns are also double-buffered behind shadow registers.

Top module: `hall_mcm_unit`

## Requirements
- R1: While reset is asserted, all pattern registers, the active mask and the pending flag are zero, both event flags are low and all six outputs sit at the passive level (0).
- R2: On a cycle with `hall_smpl` high, `hall_last` takes `hall_in` at the next edge. Without the strobe, `hall_last` holds its value.
- R3: A sample equal to the expected pattern raises `che` for exactly the cycle after the strobe. At the same edge, the current pattern takes the old expected value and the expected pattern takes the shadow expected value.
- R4: A sample equal to the current pattern but not to the expected pattern raises neither flag and leaves both reference patterns unchanged.
- R5: A sample that differs from both the current and the expected pattern raises `whe` for one cycle. `whe_irq` equals `whe` AND `whe_irq_en`.
- R6: `hall_xfer_req` copies the shadow current and shadow expected patterns into the active registers at the same edge. When it coincides with a correct event, the copy takes precedence over the advance.
- R7: `trig_sel` picks the transfer trigger: 0 none, 1 `mcm_sw_req`, 2 the registered `che` output, 3 `tmr_a_pm`. With `sync_sel` = 0 (no synchronisation), a trigger loads the active mask at the next edge.
- R8: `sync_sel` picks the synchronisation event: 1 `tmr_a_om`, 2 `tmr_b_pm`, 3 `tmr_a_pm`. A trigger without that event sets `mcm_pending`. The event then loads the mask and clears `mcm_pending` at the same edge. The event alone, with nothing pending, changes nothing.
- R9: For phase i, `ch_out[i]` is `pwm_in[i]` if mask bit 2i is set and 0 otherwise. `chn_out[i]` is the inverse of `pwm_in[i]` if mask bit 2i+1 is set and 0 otherwise. A zero mask drives all six outputs to 0.
- R10: When a shadow mask write falls in the same cycle as a transfer, the active mask receives the value the shadow held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_in | input | 3 | Hall sensor levels |
| hall_smpl | input | 1 | Sample strobe for the Hall inputs |
| hall_shd_cur | input | 3 | Value written to the shadow current pattern |
| hall_shd_exp | input | 3 | Value written to the shadow expected pattern |
| hall_shd_wr | input | 1 | Write strobe for both Hall shadow patterns |
| hall_xfer_req | input | 1 | Copy the Hall shadow patterns into the active patterns |
| whe_irq_en | input | 1 | Enable for the wrong-event interrupt |
| mcm_shd_val | input | 6 | Value written to the shadow channel mask |
| mcm_shd_wr | input | 1 | Write strobe for the shadow channel mask |
| mcm_sw_req | input | 1 | Software transfer request |
| trig_sel | input | 2 | Trigger source select for the mask transfer |
| sync_sel | input | 2 | Synchronisation event select for the mask transfer |
| tmr_a_pm | input | 1 | Timer A period event strobe |
| tmr_a_om | input | 1 | Timer A one-match event strobe |
| tmr_b_pm | input | 1 | Timer B period event strobe |
| pwm_in | input | 3 | Per-phase PWM signals |
| hall_last | output | 3 | Last sampled Hall pattern |
| hall_cur | output | 3 | Active current pattern |
| hall_exp | output | 3 | Active expected pattern |
| che | output | 1 | Correct commutation event pulse |
| whe | output | 1 | Wrong commutation event pulse |
| whe_irq | output | 1 | Wrong-event interrupt request |
| mcm_active | output | 6 | Active channel mask |
| mcm_pending | output | 1 | Mask transfer requested, waiting for synchronisation |
| ch_out | output | 3 | Gated phase outputs |
| chn_out | output | 3 | Gated complementary outputs |

## Verification
A corrupted reference pattern shows up at the very next Hall sample. Because the current and expected values are visible on the ports, the bench sees the bad value one cycle after the faulty edge. It also sees a swapped `che`/`whe` pulse after the next strobe. A stuck or lost pending flag shows on `mcm_pending` in the cycle after the trigger. It also shows at the synchronisation edge, where `mcm_active` and the gated outputs keep the old mask or take the new one too early. Every cycle, the bench compares all outputs against a model built from the requirements, so any divergence is reported in the cycle it appears.

// File: rtl/hall_mcm_pkg.sv
package hall_mcm_pkg;

   // Trigger sources for a channel-mask transfer (encoding visible at trig_sel)
   typedef enum logic [1:0] {
      TRG_OFF   = 2'd0,
      TRG_SW    = 2'd1,
      TRG_CHE   = 2'd2,
      TRG_TA_PM = 2'd3
   } trig_e;

   // Synchronisation events that complete a transfer (encoding visible at sync_sel)
   typedef enum logic [1:0] {
      SYN_NONE  = 2'd0,
      SYN_TA_OM = 2'd1,
      SYN_TB_PM = 2'd2,
      SYN_TA_PM = 2'd3
   } sync_e;

endpackage

// File: rtl/hall_compare.sv
module hall_compare #(
   parameter int HALL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALL_W-1:0] hall_in,
   input  logic              smpl,
   input  logic [HALL_W-1:0] shd_cur_in,
   input  logic [HALL_W-1:0] shd_exp_in,
   input  logic              shd_wr,
   input  logic              xfer_req,
   output logic [HALL_W-1:0] last,
   output logic [HALL_W-1:0] cur,
   output logic [HALL_W-1:0] exp_pat,
   output logic              che,
   output logic              whe
);

   if (HALL_W < 1) begin : g_bad_w
      $error("hall_compare: HALL_W must be at least 1");
   end

   logic [HALL_W-1:0] shd_cur_q, shd_exp_q;
   logic              hit_exp, hit_cur;

   assign hit_exp = smpl && (hall_in == exp_pat);
   assign hit_cur = smpl && (hall_in == cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_cur_q <= '0;
         shd_exp_q <= '0;
      end else if (shd_wr) begin
         shd_cur_q <= shd_cur_in;
         shd_exp_q <= shd_exp_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last <= '0;
      end else if (smpl) begin
         last <= hall_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         che <= 1'b0;
         whe <= 1'b0;
      end else begin
         che <= hit_exp;
         whe <= smpl && !hit_exp && !hit_cur;
      end
   end

   // Explicit transfer outranks the automatic advance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur     <= '0;
         exp_pat <= '0;
      end else if (xfer_req) begin
         cur     <= shd_cur_q;
         exp_pat <= shd_exp_q;
      end else if (hit_exp) begin
         cur     <= exp_pat;
         exp_pat <= shd_exp_q;
      end
   end

   AST_LAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smpl |=> $stable(last)); // R2
   AST_CHE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (smpl && hall_in == exp_pat && !xfer_req) |=> (che && cur == $past(exp_pat))); // R3
   AST_SAME_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (smpl && hall_in == cur && hall_in != exp_pat && !xfer_req)
      |=> (!che && !whe && $stable(cur) && $stable(exp_pat))); // R4
   AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> (cur == $past(shd_cur_q) && exp_pat == $past(shd_exp_q))); // R6

endmodule

// File: rtl/mcm_event_sel.sv
module mcm_event_sel
   import hall_mcm_pkg::*;
(
   input  logic [1:0] trig_sel,
   input  logic [1:0] sync_sel,
   input  logic       sw_req,
   input  logic       che,
   input  logic       tmr_a_pm,
   input  logic       tmr_a_om,
   input  logic       tmr_b_pm,
   output logic       trig_hit,
   output logic       sync_hit
);

   trig_e trg;
   sync_e syn;

   assign trg = trig_e'(trig_sel);
   assign syn = sync_e'(sync_sel);

   always_comb begin
      unique case (trg)
         TRG_SW:    trig_hit = sw_req;
         TRG_CHE:   trig_hit = che;
         TRG_TA_PM: trig_hit = tmr_a_pm;
         default:   trig_hit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (syn)
         SYN_TA_OM: sync_hit = tmr_a_om;
         SYN_TB_PM: sync_hit = tmr_b_pm;
         SYN_TA_PM: sync_hit = tmr_a_pm;
         default:   sync_hit = 1'b1;
      endcase
   end

endmodule

// File: rtl/mcm_shadow.sv
module mcm_shadow #(
   parameter int PAT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PAT_W-1:0] shd_val,
   input  logic             shd_wr,
   input  logic             trig_hit,
   input  logic             sync_hit,
   output logic [PAT_W-1:0] active,
   output logic             pending
);

   if (PAT_W < 2 || (PAT_W % 2) != 0) begin : g_bad_w
      $error("mcm_shadow: PAT_W must be a positive even number");
   end

   logic [PAT_W-1:0] shd_q;
   logic             go;

   assign go = (trig_hit || pending) && sync_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_q <= '0;
      end else if (shd_wr) begin
         shd_q <= shd_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= '0;
         pending <= 1'b0;
      end else begin
         if (go) begin
            active <= shd_q;
         end
         if (go) begin
            pending <= 1'b0;
         end else if (trig_hit) begin
            pending <= 1'b1;
         end
      end
   end

   AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && sync_hit) |=> !pending); // R8
   AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_hit && !sync_hit) |=> pending); // R8
   AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_hit && !pending) |=> $stable(active)); // R8
   AST_OLD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> active == $past(shd_q)); // R10

endmodule

// File: rtl/out_gate.sv
module out_gate #(
   parameter int NUM_CH      = 3,
   parameter bit PASSIVE_LVL = 1'b0,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*NUM_CH-1:0] mask,
   input  logic [NUM_CH-1:0]   pwm,
   output logic [NUM_CH-1:0]   ch_out,
   output logic [NUM_CH-1:0]   chn_out
);

   if (NUM_CH < 1) begin : g_bad_n
      $error("out_gate: NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0] ch_d, chn_d;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ph
      assign ch_d[i]  = mask[2*i]   ? pwm[i]  : PASSIVE_LVL;
      assign chn_d[i] = mask[2*i+1] ? ~pwm[i] : PASSIVE_LVL;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ch_out  <= {NUM_CH{PASSIVE_LVL}};
            chn_out <= {NUM_CH{PASSIVE_LVL}};
         end else begin
            ch_out  <= ch_d;
            chn_out <= chn_d;
         end
      end
   end else begin : g_comb
      assign ch_out  = ch_d;
      assign chn_out = chn_d;

      AST_ALL_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (mask == '0) |-> (ch_out == {NUM_CH{PASSIVE_LVL}}
                           && chn_out == {NUM_CH{PASSIVE_LVL}})); // R9
   end

endmodule

// File: rtl/hall_mcm_unit.sv
module hall_mcm_unit #(
   parameter int HALL_W      = 3,
   parameter int NUM_CH      = 3,
   parameter bit PASSIVE_LVL = 1'b0,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [HALL_W-1:0]   hall_in,
   input  logic                hall_smpl,
   input  logic [HALL_W-1:0]   hall_shd_cur,
   input  logic [HALL_W-1:0]   hall_shd_exp,
   input  logic                hall_shd_wr,
   input  logic                hall_xfer_req,
   input  logic                whe_irq_en,
   input  logic [2*NUM_CH-1:0] mcm_shd_val,
   input  logic                mcm_shd_wr,
   input  logic                mcm_sw_req,
   input  logic [1:0]          trig_sel,
   input  logic [1:0]          sync_sel,
   input  logic                tmr_a_pm,
   input  logic                tmr_a_om,
   input  logic                tmr_b_pm,
   input  logic [NUM_CH-1:0]   pwm_in,
   output logic [HALL_W-1:0]   hall_last,
   output logic [HALL_W-1:0]   hall_cur,
   output logic [HALL_W-1:0]   hall_exp,
   output logic                che,
   output logic                whe,
   output logic                whe_irq,
   output logic [2*NUM_CH-1:0] mcm_active,
   output logic                mcm_pending,
   output logic [NUM_CH-1:0]   ch_out,
   output logic [NUM_CH-1:0]   chn_out
);

   localparam int PAT_W = 2 * NUM_CH;

   logic trig_hit, sync_hit;

   hall_compare #(.HALL_W(HALL_W)) i_hall (
      .clk        (clk),
      .rst_n      (rst_n),
      .hall_in    (hall_in),
      .smpl       (hall_smpl),
      .shd_cur_in (hall_shd_cur),
      .shd_exp_in (hall_shd_exp),
      .shd_wr     (hall_shd_wr),
      .xfer_req   (hall_xfer_req),
      .last       (hall_last),
      .cur        (hall_cur),
      .exp_pat    (hall_exp),
      .che        (che),
      .whe        (whe)
   );

   assign whe_irq = whe && whe_irq_en;

   mcm_event_sel i_evt (
      .trig_sel (trig_sel),
      .sync_sel (sync_sel),
      .sw_req   (mcm_sw_req),
      .che      (che),
      .tmr_a_pm (tmr_a_pm),
      .tmr_a_om (tmr_a_om),
      .tmr_b_pm (tmr_b_pm),
      .trig_hit (trig_hit),
      .sync_hit (sync_hit)
   );

   mcm_shadow #(.PAT_W(PAT_W)) i_mcm (
      .clk      (clk),
      .rst_n    (rst_n),
      .shd_val  (mcm_shd_val),
      .shd_wr   (mcm_shd_wr),
      .trig_hit (trig_hit),
      .sync_hit (sync_hit),
      .active   (mcm_active),
      .pending  (mcm_pending)
   );

   out_gate #(
      .NUM_CH      (NUM_CH),
      .PASSIVE_LVL (PASSIVE_LVL),
      .REG_OUT     (REG_OUT)
   ) i_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask    (mcm_active),
      .pwm     (pwm_in),
      .ch_out  (ch_out),
      .chn_out (chn_out)
   );

   AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(che && whe)); // R5
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !whe |-> !whe_irq); // R5

endmodule

// File: tb/test_hall_mcm_unit.sv
`timescale 1ns/1ps
module test_hall_mcm_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_in = '0, hall_shd_cur = '0, hall_shd_exp = '0, pwm_in = '0;
   logic       hall_smpl = 0, hall_shd_wr = 0, hall_xfer_req = 0, whe_irq_en = 0;
   logic [5:0] mcm_shd_val = '0;
   logic       mcm_shd_wr = 0, mcm_sw_req = 0;
   logic [1:0] trig_sel = '0, sync_sel = '0;
   logic       tmr_a_pm = 0, tmr_a_om = 0, tmr_b_pm = 0;
   logic [2:0] hall_last, hall_cur, hall_exp, ch_out, chn_out;
   logic       che, whe, whe_irq, mcm_pending;
   logic [5:0] mcm_active;

   always #10 clk = ~clk;

   hall_mcm_unit i_hall_mcm_unit (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .hall_smpl(hall_smpl),
      .hall_shd_cur(hall_shd_cur), .hall_shd_exp(hall_shd_exp),
      .hall_shd_wr(hall_shd_wr), .hall_xfer_req(hall_xfer_req),
      .whe_irq_en(whe_irq_en), .mcm_shd_val(mcm_shd_val), .mcm_shd_wr(mcm_shd_wr),
      .mcm_sw_req(mcm_sw_req), .trig_sel(trig_sel), .sync_sel(sync_sel),
      .tmr_a_pm(tmr_a_pm), .tmr_a_om(tmr_a_om), .tmr_b_pm(tmr_b_pm), .pwm_in(pwm_in),
      .hall_last(hall_last), .hall_cur(hall_cur), .hall_exp(hall_exp),
      .che(che), .whe(whe), .whe_irq(whe_irq), .mcm_active(mcm_active),
      .mcm_pending(mcm_pending), .ch_out(ch_out), .chn_out(chn_out));

   typedef struct {
      string      tag;
      logic [2:0] last, cur, expv, co, cno;
      logic       che, whe, irq, pend;
      logic [5:0] act;
   } item_t;

   item_t q[$];
   int checks = 0, fails = 0;
   bit done = 0;

   // Model state, built from the requirements
   logic [2:0] m_last = 0, m_cur = 0, m_exp = 0, m_sc = 0, m_se = 0;
   logic       m_che = 0, m_whe = 0, m_pend = 0;
   logic [5:0] m_shd = 0, m_act = 0;

   task automatic predict(input string tag);
      item_t it;
      logic trig, sync, go;
      logic [2:0] n_last = m_last, n_cur = m_cur, n_exp = m_exp;
      logic n_che = 0, n_whe = 0;
      if (!rst_n) begin
         m_last = 0; m_cur = 0; m_exp = 0; m_sc = 0; m_se = 0;
         m_che = 0; m_whe = 0; m_pend = 0; m_shd = 0; m_act = 0;
      end else begin
         case (trig_sel)
            2'd1: trig = mcm_sw_req;
            2'd2: trig = m_che;
            2'd3: trig = tmr_a_pm;
            default: trig = 0;
         endcase
         case (sync_sel)
            2'd1: sync = tmr_a_om;
            2'd2: sync = tmr_b_pm;
            2'd3: sync = tmr_a_pm;
            default: sync = 1;
         endcase
         go = (trig || m_pend) && sync;
         if (hall_smpl) begin
            n_last = hall_in;
            if (hall_in == m_exp) begin
               n_che = 1; n_cur = m_exp; n_exp = m_se;
            end else if (hall_in != m_cur) n_whe = 1;
         end
         if (hall_xfer_req) begin
            n_cur = m_sc; n_exp = m_se;
         end
         if (hall_shd_wr) begin
            m_sc = hall_shd_cur; m_se = hall_shd_exp;
         end
         if (go) m_act = m_shd;
         m_pend = go ? 1'b0 : (trig ? 1'b1 : m_pend);
         if (mcm_shd_wr) m_shd = mcm_shd_val;
         m_last = n_last; m_cur = n_cur; m_exp = n_exp; m_che = n_che; m_whe = n_whe;
      end
      it.tag = tag; it.last = m_last; it.cur = m_cur; it.expv = m_exp;
      it.che = m_che; it.whe = m_whe; it.irq = m_whe && whe_irq_en;
      it.act = m_act; it.pend = m_pend;
      for (int i = 0; i < 3; i++) begin
         it.co[i]  = m_act[2*i]   ? pwm_in[i]  : 1'b0;
         it.cno[i] = m_act[2*i+1] ? ~pwm_in[i] : 1'b0;
      end
      q.push_back(it);
   endtask

   // Driver: inputs already set at a falling edge; push, wait, clear strobes
   task automatic cyc(input string tag);
      predict(tag);
      @(negedge clk);
      hall_smpl = 0; hall_shd_wr = 0; hall_xfer_req = 0; mcm_shd_wr = 0;
      mcm_sw_req = 0; tmr_a_pm = 0; tmr_a_om = 0; tmr_b_pm = 0;
   endtask

   task automatic chk(input string tag, input string f, input int a, input int e);
      checks++;
      if (a !== e) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, f, a, e, $time);
      end
   endtask

   // Monitor: pops one expected item per edge, compares after it settles
   initial begin
      item_t e;
      forever begin
         @(posedge clk); #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "hall_last", hall_last, e.last);
            chk(e.tag, "hall_cur", hall_cur, e.cur);
            chk(e.tag, "hall_exp", hall_exp, e.expv);
            chk(e.tag, "che", che, e.che);
            chk(e.tag, "whe", whe, e.whe);
            chk(e.tag, "whe_irq", whe_irq, e.irq);
            chk(e.tag, "mcm_active", mcm_active, e.act);
            chk(e.tag, "mcm_pending", mcm_pending, e.pend);
            chk(e.tag, "ch_out", ch_out, e.co);
            chk(e.tag, "chn_out", chn_out, e.cno);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      cyc("R1"); cyc("R1");
      rst_n = 1;
      // Load references: current 1, expected 3; next expected 2
      hall_shd_cur = 3'd1; hall_shd_exp = 3'd3; hall_shd_wr = 1; cyc("R6");
      hall_xfer_req = 1; cyc("R6");
      hall_shd_exp = 3'd2; hall_shd_wr = 1; cyc("R6");
      hall_in = 3'd1; hall_smpl = 1; cyc("R4");
      cyc("R4");
      hall_in = 3'd3; hall_smpl = 1; cyc("R3");
      cyc("R3");
      hall_in = 3'd6; cyc("R2"); cyc("R2");
      whe_irq_en = 1; hall_in = 3'd5; hall_smpl = 1; cyc("R5");
      cyc("R5");
      whe_irq_en = 0; hall_in = 3'd7; hall_smpl = 1; cyc("R5");
      cyc("R5");
      // Transfer coincides with a correct event (expected is 2)
      hall_shd_cur = 3'd4; hall_shd_exp = 3'd6; hall_shd_wr = 1; cyc("R6");
      hall_in = 3'd2; hall_smpl = 1; hall_xfer_req = 1; cyc("R6");
      cyc("R6");
      // Immediate transfer on software request
      trig_sel = 2'd1; sync_sel = 2'd0;
      mcm_shd_val = 6'b010101; mcm_shd_wr = 1; cyc("R7");
      mcm_sw_req = 1; cyc("R7");
      for (int p = 0; p < 8; p++) begin
         pwm_in = 3'(p); cyc("R9");
      end
      // Trigger type 0 ignores the request
      trig_sel = 2'd0; mcm_shd_val = 6'b111111; mcm_shd_wr = 1; cyc("R7");
      mcm_sw_req = 1; cyc("R7"); cyc("R7");
      // Held transfer completed by timer B
      trig_sel = 2'd1; sync_sel = 2'd2;
      mcm_shd_val = 6'b101010; mcm_shd_wr = 1; cyc("R8");
      tmr_b_pm = 1; cyc("R8");
      mcm_sw_req = 1; cyc("R8");
      tmr_a_om = 1; tmr_a_pm = 1; cyc("R8");
      cyc("R8");
      tmr_b_pm = 1; cyc("R8");
      for (int p = 0; p < 8; p++) begin
         pwm_in = 3'(p); cyc("R9");
      end
      // Correct event as trigger, timer A one-match as sync (expected is 6)
      trig_sel = 2'd2; sync_sel = 2'd1;
      mcm_shd_val = 6'b000111; mcm_shd_wr = 1; cyc("R7");
      hall_in = 3'd6; hall_smpl = 1; cyc("R7");
      cyc("R7"); cyc("R8");
      tmr_a_om = 1; cyc("R8");
      cyc("R8");
      // Timer A period as both trigger and sync
      trig_sel = 2'd3; sync_sel = 2'd3;
      mcm_shd_val = 6'b111000; mcm_shd_wr = 1; cyc("R7");
      tmr_a_pm = 1; cyc("R7");
      cyc("R7");
      // Shadow write in the same cycle as the transfer
      trig_sel = 2'd1; sync_sel = 2'd0;
      mcm_shd_val = 6'b011001; mcm_shd_wr = 1; cyc("R10");
      mcm_shd_val = 6'b100110; mcm_shd_wr = 1; mcm_sw_req = 1; cyc("R10");
      cyc("R10");
      mcm_sw_req = 1; cyc("R10");
      // Zero mask: all passive
      mcm_shd_val = 6'b000000; mcm_shd_wr = 1; cyc("R9");
      mcm_sw_req = 1; cyc("R9");
      for (int p = 0; p < 8; p++) begin
         pwm_in = 3'(p); cyc("R9");
      end
      // Reset mid-run clears everything
      rst_n = 0; cyc("R1"); cyc("R1");
      @(posedge clk); #3;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule